// File: doc/BRIEF.md
# I2t Overcurrent Trip Engine

This block decides when a power switch must be opened to protect its wiring. On every sample strobe it receives a current magnitude as an unsigned code. The code is scaled so that `RATED_CODE` stands for the switch's rated current. The block keeps a heat estimate that rises with the square of any current above a heating threshold. Below that threshold the estimate cools at a fixed rate. When the estimate reaches a trip constant while the switch is on, the block requests a trip. A separate comparator requests a trip at once when the current exceeds a short-circuit level, without waiting for the estimate.

The heat estimate is not cleared when the switch opens or trips. It therefore acts as a thermal memory: closing the switch again into an overload soon after a trip gives a shorter trip time than the first one did. The trip request is a single-cycle pulse to the external on/off latch and comes with a cause flag. After a pulse the block stays silent until the switch has been seen off, which re-arms it.

With the default parameters, the rated current is code 64, the heating threshold is code 80 (125 %) and the short-circuit level is code 768 (1200 %). The time to trip in strobes is ceil(K / (I² − Ith²)), so it falls with the square of the overload.

Top module: `i2t_trip_engine`

## Requirements
- R1: A strobe whose current code is at or below `ITH_CODE` (default 80) never produces a trip, no matter how many such strobes occur.
- R2: A strobe with a current code above `ITH_CODE` adds cur² − ITH_CODE² to the heat estimate. The result saturates at 2^ACC_W − 1 and never wraps.
- R3: If a strobe finds the switch on, the block armed and the current above `ITH_CODE`, and the updated heat reaches `K_LIMIT`, then `trip_o` is high in the cycle after that strobe's clock edge with `trip_cause_o` = 0. From zero heat, a constant current I trips on strobe ceil(K_LIMIT / (I² − ITH_CODE²)).
- R4: If a strobe finds the switch on and the block armed with a current code strictly above `INST_CODE` (default 768), then `trip_o` is high in the next cycle with `trip_cause_o` = 1, whatever the heat. This cause takes priority when both paths fire. A code equal to `INST_CODE` is handled only by the heat path.
- R5: A strobe with a current code at or below `ITH_CODE` lowers the heat by `DECAY_STEP` (default 1024), floored at zero.
- R6: Neither a switch-off nor a trip clears the heat, so a turn-on into overload before full cooling trips in fewer strobes than from cold.
- R7: `trip_o` lasts one cycle. After a trip no further trip occurs until `sw_on_i` has been low for at least one cycle.
- R8: No trip occurs while `sw_on_i` is low. The heat does not change on cycles without a strobe.
- R9: After reset the heat is zero, the block is armed and `trip_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Strobe: `cur_i` holds a new sample |
| cur_i | input | CUR_W | Load current magnitude code |
| sw_on_i | input | 1 | Switch is commanded on |
| trip_o | output | 1 | One-cycle trip request |
| trip_cause_o | output | 1 | Cause of the trip: 0 heat path, 1 short-circuit path |

## Verification
Both trip paths are registered once. The pulse for a strobe captured at a rising edge is therefore visible during the following cycle and gone one edge later. The bench sets inputs at a falling edge and reads `trip_o` at the next falling edge, so each read belongs to exactly the strobe just applied. This lets a trip be counted to the exact strobe index that R3 predicts. Heat, which is not visible at the ports, is inferred from those strobe counts after chosen numbers of cooling strobes. The counts are exact because the decay and saturation arithmetic gives one exact value.

// File: rtl/i2t_pkg.sv
package i2t_pkg;

    typedef enum logic {
        CAUSE_HEAT  = 1'b0,
        CAUSE_SHORT = 1'b1
    } trip_cause_e;

endpackage

// File: rtl/i2t_excess_calc.sv
module i2t_excess_calc #(
    parameter int CUR_W     = 10,
    parameter int ITH_CODE  = 80,
    parameter int INST_CODE = 768
) (
    input  logic [CUR_W-1:0]   cur_i,
    output logic               heating_o,
    output logic               short_o,
    output logic [2*CUR_W-1:0] excess_o
);
    localparam int SQ_W = 2 * CUR_W;
    localparam logic [SQ_W-1:0] ITH_SQ = SQ_W'(ITH_CODE * ITH_CODE);

    logic [SQ_W-1:0] sq;

    always_comb begin
        sq        = SQ_W'(cur_i) * SQ_W'(cur_i);
        heating_o = cur_i > CUR_W'(ITH_CODE);
        short_o   = cur_i > CUR_W'(INST_CODE);
        excess_o  = heating_o ? (sq - ITH_SQ) : '0;
    end
endmodule

// File: rtl/i2t_heat_update.sv
module i2t_heat_update #(
    parameter int ACC_W      = 22,
    parameter int SQ_W       = 20,
    parameter int DECAY_STEP = 1024
) (
    input  logic [ACC_W-1:0] heat_q_i,
    input  logic             strobe_i,
    input  logic             heating_i,
    input  logic [SQ_W-1:0]  excess_i,
    output logic [ACC_W-1:0] heat_d_o
);
    localparam int SUM_W = ((ACC_W > SQ_W) ? ACC_W : SQ_W) + 1;
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] DECAY   = ACC_W'(DECAY_STEP);

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum      = SUM_W'(heat_q_i) + SUM_W'(excess_i);
        heat_d_o = heat_q_i;
        if (strobe_i) begin
            if (heating_i) begin
                heat_d_o = (sum > SUM_W'(ACC_MAX)) ? ACC_MAX : sum[ACC_W-1:0];
            end else begin
                heat_d_o = (heat_q_i > DECAY) ? (heat_q_i - DECAY) : '0;
            end
        end
    end
endmodule

// File: rtl/i2t_trip_engine.sv
module i2t_trip_engine
    import i2t_pkg::*;
#(
    parameter int CUR_W      = 10,
    parameter int ACC_W      = 22,
    parameter int ITH_CODE   = 80,
    parameter int INST_CODE  = 768,
    parameter int K_LIMIT    = 1048576,
    parameter int DECAY_STEP = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld_i,
    input  logic [CUR_W-1:0] cur_i,
    input  logic             sw_on_i,
    output logic             trip_o,
    output logic             trip_cause_o
);
    localparam int SQ_W = 2 * CUR_W;
    localparam logic [ACC_W-1:0] K_THR = ACC_W'(K_LIMIT);

    typedef struct packed {
        logic [ACC_W-1:0] heat;
        logic             armed;
        logic             trip;
        trip_cause_e      cause;
    } state_t;

    state_t st_d, st_q;

    logic             heating;
    logic             short_hit;
    logic [SQ_W-1:0]  excess;
    logic [ACC_W-1:0] heat_q;
    logic [ACC_W-1:0] heat_next;
    logic             armed_q;

    assign heat_q  = st_q.heat;
    assign armed_q = st_q.armed;

    i2t_excess_calc #(
        .CUR_W    (CUR_W),
        .ITH_CODE (ITH_CODE),
        .INST_CODE(INST_CODE)
    ) u_excess (
        .cur_i    (cur_i),
        .heating_o(heating),
        .short_o  (short_hit),
        .excess_o (excess)
    );

    i2t_heat_update #(
        .ACC_W     (ACC_W),
        .SQ_W      (SQ_W),
        .DECAY_STEP(DECAY_STEP)
    ) u_heat (
        .heat_q_i (heat_q),
        .strobe_i (sample_vld_i),
        .heating_i(heating),
        .excess_i (excess),
        .heat_d_o (heat_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.heat = heat_next;
        st_d.trip = 1'b0;
        if (!sw_on_i) begin
            st_d.armed = 1'b1;
        end
        if (sample_vld_i && sw_on_i && armed_q) begin
            if (short_hit) begin
                st_d.trip  = 1'b1;
                st_d.cause = CAUSE_SHORT;
                st_d.armed = 1'b0;
            end else if (heating && (heat_next >= K_THR)) begin
                st_d.trip  = 1'b1;
                st_d.cause = CAUSE_HEAT;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{heat: '0, armed: 1'b1, trip: 1'b0, cause: CAUSE_HEAT};
        end else begin
            st_q <= st_d;
        end
    end

    assign trip_o       = st_q.trip;
    assign trip_cause_o = st_q.cause;
endmodule

// File: rtl/i2t_trip_engine_chk.sv
module i2t_trip_engine_chk #(
    parameter int CUR_W     = 10,
    parameter int ACC_W     = 22,
    parameter int ITH_CODE  = 80,
    parameter int INST_CODE = 768,
    parameter int K_LIMIT   = 1048576
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_vld_i,
    input logic [CUR_W-1:0] cur_i,
    input logic             sw_on_i,
    input logic             trip_o,
    input logic             trip_cause_o,
    input logic [ACC_W-1:0] heat_q,
    input logic             armed_q
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    AST_COOL_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && cur_i <= CUR_W'(ITH_CODE)) |=> !trip_o); // R1
    AST_HEAT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && cur_i > CUR_W'(ITH_CODE) && heat_q != ACC_MAX) |=> heat_q > $past(heat_q)); // R2
    AST_HEAT_TRIP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && !trip_cause_o) |-> heat_q >= ACC_W'(K_LIMIT)); // R3
    AST_SHORT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && sw_on_i && armed_q && cur_i > CUR_W'(INST_CODE)) |=> (trip_o && trip_cause_o)); // R4
    AST_HEAT_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_i && cur_i <= CUR_W'(ITH_CODE) && heat_q != '0) |=> heat_q < $past(heat_q)); // R5
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |=> !trip_o); // R7
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_on_i |=> !trip_o); // R8
    AST_HEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld_i |=> $stable(heat_q)); // R8
endmodule

bind i2t_trip_engine i2t_trip_engine_chk #(
    .CUR_W    (CUR_W),
    .ACC_W    (ACC_W),
    .ITH_CODE (ITH_CODE),
    .INST_CODE(INST_CODE),
    .K_LIMIT  (K_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld_i(sample_vld_i),
    .cur_i       (cur_i),
    .sw_on_i     (sw_on_i),
    .trip_o      (trip_o),
    .trip_cause_o(trip_cause_o),
    .heat_q      (heat_q),
    .armed_q     (armed_q)
);

// File: tb/i2t_trip_engine_bench.sv
module i2t_trip_engine_bench;
    localparam int CUR_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sample_vld_i = 1'b0;
    logic [CUR_W-1:0] cur_i = '0;
    logic             sw_on_i = 1'b0;
    logic             trip_o;
    logic             trip_cause_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    i2t_trip_engine u_i2t_trip_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_vld_i(sample_vld_i),
        .cur_i       (cur_i),
        .sw_on_i     (sw_on_i),
        .trip_o      (trip_o),
        .trip_cause_o(trip_cause_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply one cycle of inputs; on return trip_o reflects this cycle's strobe.
    task automatic step(input bit v, input int c, input bit on);
        sample_vld_i = v;
        cur_i        = c[CUR_W-1:0];
        sw_on_i      = on;
        @(negedge clk);
    endtask

    task automatic run_trip(input int c, input int limit, output int n, output int cause);
        n = 0;
        cause = -1;
        for (int i = 1; i <= limit; i++) begin
            step(1'b1, c, 1'b1);
            if (trip_o) begin
                n = i;
                cause = int'(trip_cause_o);
                break;
            end
        end
    endtask

    task automatic cool_off(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 0, 1'b0);
    endtask

    task automatic t_reset;
        check(trip_o == 1'b0, "R9", "trip during reset", int'(trip_o), 0);
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0);
        check(trip_o == 1'b0, "R9", "trip after reset", int'(trip_o), 0);
    endtask

    task automatic t_never;
        int trips = 0;
        for (int i = 0; i < 2000; i++) begin
            step(1'b1, 70, 1'b1);
            if (trip_o) trips++;
        end
        check(trips == 0, "R1", "trips at 109%", trips, 0);
        trips = 0;
        for (int i = 0; i < 50; i++) begin
            step(1'b1, 80, 1'b1);
            if (trip_o) trips++;
        end
        check(trips == 0, "R1", "trips at threshold", trips, 0);
    endtask

    task automatic t_first;
        int n, cause;
        run_trip(96, 1000, n, cause);
        check(n == 373, "R3", "strobes to trip at 150% from cold (R9 zero heat)", n, 373);
        check(cause == 0, "R3", "cause", cause, 0);
    endtask

    task automatic t_memory;
        int n, cause;
        cool_off(100);
        run_trip(96, 1000, n, cause);
        check(n == 36, "R6", "retrip strobes after short cooling", n, 36);
    endtask

    task automatic t_inverse;
        int n, cause;
        cool_off(1100);
        run_trip(88, 2000, n, cause);
        check(n == 781, "R5", "strobes at 137.5% after full decay (R2)", n, 781);
    endtask

    task automatic t_heavy;
        int n, cause;
        cool_off(1100);
        run_trip(512, 100, n, cause);
        check(n == 5, "R3", "strobes at 800%", n, 5);
        check(cause == 0, "R3", "cause at 800%", cause, 0);
        cool_off(1300);
        run_trip(768, 100, n, cause);
        check(n == 2, "R4", "strobes at exactly short level", n, 2);
        check(cause == 0, "R4", "cause at exactly short level", cause, 0);
    endtask

    task automatic t_instant;
        int n, cause;
        int trips = 0;
        cool_off(1200);
        run_trip(800, 10, n, cause);
        check(n == 1, "R4", "strobes above short level", n, 1);
        check(cause == 1, "R4", "cause above short level", cause, 1);
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 800, 1'b1);
            if (trip_o) trips++;
        end
        check(trips == 0, "R7", "trips without re-arm", trips, 0);
        step(1'b0, 0, 1'b0);
        run_trip(800, 10, n, cause);
        check(n == 1, "R7", "strobes after re-arm", n, 1);
        check(cause == 1, "R4", "short cause wins over full heat", cause, 1);
    endtask

    task automatic t_saturate;
        int n, cause;
        for (int i = 0; i < 10; i++) step(1'b1, 1023, 1'b0);
        cool_off(4094);
        run_trip(96, 1000, n, cause);
        check(n == 372, "R2", "strobes after saturated heat decays", n, 372);
    endtask

    task automatic t_off;
        int n, cause;
        int trips = 0;
        cool_off(1100);
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 800, 1'b0);
            if (trip_o) trips++;
        end
        check(trips == 0, "R8", "trips while off", trips, 0);
        trips = 0;
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 800, 1'b1);
            if (trip_o) trips++;
        end
        check(trips == 0, "R8", "trips without strobe", trips, 0);
        run_trip(96, 1000, n, cause);
        check(n == 1 && cause == 0, "R6", "heat kept from off strobes", n, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_never();
        t_first();
        t_memory();
        t_inverse();
        t_heavy();
        t_instant();
        t_saturate();
        t_off();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule